// File: doc/BRIEF.md
# I2C Bus-Lock Recovery Unit

This unit decides whether a target device on an I2C bus has been left holding SDA low, and if so it frees the bus by clocking SCL until the device lets go. It observes the already-synchronized SCL and SDA levels. Its only drive onto the bus is an open-drain pull-low enable for SCL. SDA is never driven. The controller that owns the bus starts the unit after it has released both lines, for example after an abort or a lost arbitration. The unit also runs once by itself when reset is released. Issuing a STOP condition afterwards is left to that controller.

A check has two phases. First comes a watch phase of ten half-periods. During that phase the unit requires SDA low and SCL high on every cycle. Any break in that condition means some other bus activity, not a lock, and the unit finishes without touching SCL. If the condition lasts the full window, the unit issues up to ten clock pulses. Each pulse holds SCL low for one half-period and then releases it for one half-period. SDA is sampled when each released half ends, and pulsing stops as soon as SDA reads high. A one-cycle done strobe then reports whether a lock was seen and whether SDA was still low after the last pulse.

Top module: `i2c_bus_unlock`

## Requirements
- R1: While reset is high, `scl_pull_o`, `busy_o` and `done_o` are 0. On the first clock edge after reset is released, a check starts without any start request.
- R2: In the idle state, `start_i` high at a clock edge (edge E0) starts a check. `busy_o` reads 1 after E0. `half_period_i` is captured at E0 as the half-period H in clock cycles, and a value of 0 is treated as 1.
- R3: In the watch phase, the lock condition (SDA low and SCL high) is sampled at every edge E1, E2, and so on. If it is false at edge Ek with k ≤ 10·H, done is raised at Ek with `lock_seen_o`=0 and `lock_held_o`=0, and SCL is never pulled.
- R4: If the lock condition holds at every edge up to and including E(10·H), `scl_pull_o` goes to 1 at E(10·H) and `lock_seen_o` reads 1 at the done strobe.
- R5: Pulse n (counting from 1) pulls SCL low from edge E(10·H+2·H·(n−1)) to E(10·H+2·H·(n−1)+H), so each low period is H cycles, and then SCL is released for H cycles.
- R6: SDA is sampled at the end of every released half, at E(10·H+2·H·n). If it is high, the check ends at that edge with done, `lock_seen_o`=1 and `lock_held_o`=0, after exactly n pulses.
- R7: If SDA is still low at the end of the tenth pulse, done is raised at E(30·H) with `lock_seen_o`=1 and `lock_held_o`=1.
- R8: `done_o` is high for exactly one cycle, and `busy_o` falls at the same edge at which `done_o` rises.
- R9: `start_i` has no effect while `busy_o` is 1. The timing and results of the running check are unchanged, and no new check starts unless `start_i` is high in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| start_i | input | 1 | Request a lock check (honoured only when idle) |
| half_period_i | input | HALF_W | Half-period in clock cycles, captured at start |
| scl_pull_o | output | 1 | 1 = pull SCL low (open drain) |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle strobe at the end of a check |
| lock_seen_o | output | 1 | The watch phase found a lock (valid with done) |
| lock_held_o | output | 1 | SDA was still low after the last pulse (valid with done) |

## Verification
The assertions assume that the bus reflects the unit's own SCL drive. While `scl_pull_o` is high, SCL reads low, and no other agent stretches the clock during a released half. The bench models SCL as the inverse of the pull enable, with an extra pull-low term that is used only during the watch phase, so the stimulus stays inside that assumption. SDA and the extra SCL term change only at falling edges. Each release point is therefore tied to a known sampling edge. The sweep covers every release cycle of the watch window and every pulse count from one to ten, plus the never-released case, for several half-period values including zero.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WATCH = 2'd1,
    ST_PULL  = 2'd2,
    ST_FREE  = 2'd3
  } unlock_st_e;
endpackage

// File: rtl/unlock_halftick.sv
// Free-running half-period timer; restart aligns it to a new check.
module unlock_halftick #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [HALF_W-1:0] span,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q;

  assign tick = (cnt_q == span - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/unlock_counter.sv
// Event counter that flags the event which completes the LIMIT-th step.
module unlock_counter #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign last = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_bus_unlock.sv
module i2c_bus_unlock
  import unlock_pkg::*;
#(
  parameter int HALF_W       = 8,
  parameter int WATCH_HALVES = 10,
  parameter int PULSE_MAX    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              start_i,
  input  logic [HALF_W-1:0] half_period_i,
  output logic              scl_pull_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              lock_seen_o,
  output logic              lock_held_o
);
  unlock_st_e        st_q;
  logic              boot_q;
  logic [HALF_W-1:0] hp_q;
  logic              accept;
  logic              tick;
  logic              watch_last;
  logic              pulse_last;
  logic              stuck;

  assign accept = (st_q == ST_IDLE) && (start_i || boot_q);
  assign stuck  = !sda_in && scl_in;

  unlock_halftick #(.HALF_W(HALF_W)) u_tick (
    .clk(clk), .rst(rst), .restart(accept), .span(hp_q), .tick(tick)
  );

  unlock_counter #(.LIMIT(WATCH_HALVES)) u_watch_cnt (
    .clk(clk), .rst(rst), .clr(accept),
    .inc((st_q == ST_WATCH) && tick), .last(watch_last)
  );

  unlock_counter #(.LIMIT(PULSE_MAX)) u_pulse_cnt (
    .clk(clk), .rst(rst), .clr(accept),
    .inc((st_q == ST_FREE) && tick), .last(pulse_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      boot_q      <= 1'b1;
      hp_q        <= HALF_W'(1);
      scl_pull_o  <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      lock_seen_o <= 1'b0;
      lock_held_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            boot_q      <= 1'b0;
            hp_q        <= (half_period_i == '0) ? HALF_W'(1) : half_period_i;
            busy_o      <= 1'b1;
            lock_seen_o <= 1'b0;
            lock_held_o <= 1'b0;
            st_q        <= ST_WATCH;
          end
        end
        ST_WATCH: begin
          if (!stuck) begin
            done_o <= 1'b1;
            busy_o <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (tick && watch_last) begin
            lock_seen_o <= 1'b1;
            scl_pull_o  <= 1'b1;
            st_q        <= ST_PULL;
          end
        end
        ST_PULL: begin
          if (tick) begin
            scl_pull_o <= 1'b0;
            st_q       <= ST_FREE;
          end
        end
        ST_FREE: begin
          if (tick) begin
            if (sda_in) begin
              done_o <= 1'b1;
              busy_o <= 1'b0;
              st_q   <= ST_IDLE;
            end else if (pulse_last) begin
              lock_held_o <= 1'b1;
              done_o      <= 1'b1;
              busy_o      <= 1'b0;
              st_q        <= ST_IDLE;
            end else begin
              scl_pull_o <= 1'b1;
              st_q       <= ST_PULL;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/unlock_checks.sv
module unlock_checks #(
  parameter int PULSE_MAX = 10
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic scl_pull_o,
  input logic busy_o,
  input logic done_o,
  input logic lock_seen_o,
  input logic lock_held_o
);
  localparam int PCW = $clog2(PULSE_MAX + 2);
  logic [PCW-1:0] pulses_q;
  logic           pull_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulses_q    <= '0;
      pull_prev_q <= 1'b0;
    end else begin
      pull_prev_q <= scl_pull_o;
      if (done_o)                         pulses_q <= '0;
      else if (scl_pull_o && !pull_prev_q) pulses_q <= pulses_q + 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);                                           // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));                        // R8
  AST_PULL_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    scl_pull_o |-> busy_o);                                        // R5
  AST_WATCH_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !scl_pull_o);                                // R3
  AST_NOLOCK_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    (done_o && !lock_seen_o) |-> (pulses_q == '0));                // R3
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pulses_q <= PCW'(PULSE_MAX)));                     // R7
  AST_HELD_NEEDS_SEEN: assert property (@(posedge clk) disable iff (rst)
    (done_o && lock_held_o) |-> lock_seen_o);                      // R7
  AST_BUSY_ONLY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || done_o));                   // R9
endmodule

bind i2c_bus_unlock unlock_checks #(.PULSE_MAX(PULSE_MAX)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .scl_pull_o(scl_pull_o),
  .busy_o(busy_o), .done_o(done_o), .lock_seen_o(lock_seen_o),
  .lock_held_o(lock_held_o)
);

// File: tb/sim_i2c_bus_unlock.sv
module sim_i2c_bus_unlock;
  localparam int HW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [HW-1:0] half_period = '0;
  logic          sda_low = 1'b0;
  logic          ext_scl_low = 1'b0;
  logic          scl_pull, busy, done, seen, held;
  logic          scl_line, sda_line;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  assign scl_line = !(scl_pull || ext_scl_low);
  assign sda_line = !sda_low;

  always #10 clk = ~clk;

  i2c_bus_unlock #(.HALF_W(HW)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl_line), .sda_in(sda_line),
    .start_i(start), .half_period_i(half_period),
    .scl_pull_o(scl_pull), .busy_o(busy), .done_o(done),
    .lock_seen_o(seen), .lock_held_o(held)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // rel_w: edge index at which the lock condition is first false (0 = never)
  // rel_p: pulse count after which SDA is released (>10 = never)
  task automatic run_case(input int hp, input int rel_w, input bit via_scl,
                          input int rel_p, input bit hold_start, input string req);
    int hpe;
    int edges;
    int pulses;
    int lowrun;
    int badw;
    int badbusy;
    bit prev;
    bit got_seen;
    bit got_held;
    int exp_e;
    int exp_p;
    bit exp_seen;
    bit exp_held;
    hpe = (hp == 0) ? 1 : hp;
    edges = 0; pulses = 0; lowrun = 0; badw = 0; badbusy = 0;
    prev = 1'b0; got_seen = 1'b0; got_held = 1'b0;
    half_period = HW'(hp);
    sda_low = 1'b1;
    ext_scl_low = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    if (rel_w == 1) begin
      if (via_scl) ext_scl_low = 1'b1; else sda_low = 1'b0;
    end
    while (edges < 400) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (done) begin
        got_seen = seen;
        got_held = held;
        if (busy) badbusy++;
        break;
      end
      if (!busy) badbusy++;
      if (scl_pull) lowrun++;
      if (prev && !scl_pull) begin
        pulses++;
        if (lowrun != hpe) badw++;
        lowrun = 0;
        if (pulses == rel_p) sda_low = 1'b0;
      end
      prev = scl_pull;
      if (rel_w > 1 && edges == rel_w - 1) begin
        if (via_scl) ext_scl_low = 1'b1; else sda_low = 1'b0;
      end
    end
    start = 1'b0;
    if (rel_w > 0) begin
      exp_e = rel_w; exp_p = 0; exp_seen = 1'b0; exp_held = 1'b0;
    end else if (rel_p <= 10) begin
      exp_e = 10*hpe + 2*hpe*rel_p; exp_p = rel_p; exp_seen = 1'b1; exp_held = 1'b0;
    end else begin
      exp_e = 30*hpe; exp_p = 10; exp_seen = 1'b1; exp_held = 1'b1;
    end
    chk(edges == exp_e, req, "done edge", edges, exp_e);
    chk(pulses == exp_p, req, "pulse count", pulses, exp_p);
    chk(got_seen == exp_seen, req, "lock_seen", int'(got_seen), int'(exp_seen));
    chk(got_held == exp_held, req, "lock_held", int'(got_held), int'(exp_held));
    chk(badw == 0, "R5", "pulse low width errors", badw, 0);
    chk(badbusy == 0, "R8", "busy mismatches", badbusy, 0);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done width", int'(done), 0);
    chk(busy == 1'b0, "R9", "idle after done", int'(busy), 0);
    sda_low = 1'b0;
    ext_scl_low = 1'b0;
  endtask

  initial begin
    // R1: reset state, then a self-started check on an idle bus
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(scl_pull == 1'b0, "R1", "pull in reset", int'(scl_pull), 0);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R1", "boot check busy", int'(busy), 1);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R1", "boot check done", int'(done), 1);
    chk(seen == 1'b0, "R1", "boot lock_seen", int'(seen), 0);
    repeat (2) @(negedge clk);

    for (int hp = 0; hp <= 3; hp++) begin
      for (int k = 1; k <= 10 * ((hp == 0) ? 1 : hp); k++) begin
        run_case(hp, k, 1'b0, 99, 1'b0, "R3");
        run_case(hp, k, 1'b1, 99, 1'b0, "R3");
      end
      for (int r = 1; r <= 10; r++) run_case(hp, 0, 1'b0, r, 1'b0, (r == 1) ? "R4" : "R6");
      run_case(hp, 0, 1'b0, 11, 1'b0, "R7");
    end
    // R9: start held high for the whole check
    run_case(2, 0, 1'b0, 3, 1'b1, "R9");
    run_case(3, 7, 1'b0, 99, 1'b1, "R9");
    // R2: zero half-period behaves as one
    run_case(0, 0, 1'b0, 11, 1'b0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule